// File: doc/BRIEF.md
# Audio Bit and Frame Clock Generator

This block derives the bit-rate and frame-rate timing for a PCM serial audio port. It runs entirely in one system clock domain. The two candidate audio clocks reach it as single-cycle enable strobes, so no clock is gated or multiplexed. A 16-bit control word picks the strobe source and sets two divide ratios. The first ratio turns source strobes into bit ticks. The second ratio groups bit ticks into frames.

The outputs are single-cycle enables for the shifter logic:
- a bit tick marking each bit boundary, which the transmit side uses to launch data;
- a mid-bit receive enable for sampling;
- a frame-start pulse;
- a frame-sync level one bit wide.

The frame divider runs at all times. It keeps counting even when the shifters take their frame sync from an external pin.

Top module: `audio_clkgen`

## Requirements
- R1: Reset clears the control word and all outputs. With the cleared word, the auxiliary strobe is the source and both ratios are divide-by-1, so every auxiliary strobe yields a bit tick that also starts a frame.
- R2: Control bit 0 picks the source: 0 takes `aux_tick`, 1 takes `hs_tick`. Strobes on the source that is not picked have no effect on any output.
- R3: Control bits 15:8 hold a value B. A bit period lasts N = B+1 source strobes. `bit_tick` is high for one cycle, in the cycle after the N-th strobe of each period.
- R4: Control bits 7:1 hold a value F. A frame lasts F+1 bit ticks. `frame_tick` pulses together with the first bit tick of each frame. The first bit tick after the counters restart begins a frame.
- R5: The largest frame ratio, F = 127, gives exactly 128 bit ticks per frame.
- R6: `fsync` goes high in the cycle of a frame-starting bit tick. It stays high until the next bit tick, so it is exactly one bit period wide.
- R7: `rx_en` pulses once per bit period, in the cycle after the source strobe of index N/2-1 (integer division, counting from 0). For N = 1 it coincides with `bit_tick`.
- R8: A change to either ratio written with an unchanged source bit takes effect only when the running bit or frame period ends. The period in progress is completed with the old ratio.
- R9: A write that changes the source bit restarts both counters at once and loads the new ratios immediately. It also clears `fsync`. After such a write, the first bit tick needs a full new period and starts a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word: [15:8] bit ratio, [7:1] frame ratio, [0] source |
| aux_tick | input | 1 | Auxiliary audio clock enable strobe |
| hs_tick | input | 1 | High-speed audio clock enable strobe |
| bit_tick | output | 1 | One-cycle pulse at each bit boundary |
| rx_en | output | 1 | One-cycle mid-bit receive sample enable |
| frame_tick | output | 1 | One-cycle pulse on the first bit of each frame |
| fsync | output | 1 | Frame sync level, one bit period wide |

## Verification
Each output is registered once after the strobe that causes it. `bit_tick`, `rx_en`, `frame_tick` and the new `fsync` level therefore appear in the cycle after the source strobe is sampled. A control write acts from the cycle after `cfg_wr` is sampled. The bench drives each strobe for one cycle and samples the outputs on the next falling edge, one full cycle after the strobe was taken. Table runs count pulses over whole sequences and wait several cycles after the last strobe, so the final pulse is always counted.

// File: rtl/audio_clkgen.sv
module audio_clkgen #(
  parameter int BDIV_W = 8,
  parameter int FDIV_W = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [15:0] cfg_wdata,
  input  logic        aux_tick,
  input  logic        hs_tick,
  output logic        bit_tick,
  output logic        rx_en,
  output logic        frame_tick,
  output logic        fsync
);
  localparam int CW = BDIV_W + FDIV_W + 1;

  logic [CW-1:0]     cfg;
  logic [BDIV_W-1:0] bcnt, bdiv;
  logic [FDIV_W-1:0] fcnt, fdiv;
  logic [BDIV_W:0]   half;
  logic [BDIV_W-1:0] rx_idx;

  wire src_chg = cfg_wr && (cfg_wdata[0] != cfg[0]);
  wire sel     = cfg[0] ? hs_tick : aux_tick;

  assign half   = ({1'b0, bdiv} + 1'b1) >> 1;
  assign rx_idx = (bdiv == '0) ? '0 : half[BDIV_W-1:0] - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg        <= '0;
      bcnt       <= '0;
      bdiv       <= '0;
      fcnt       <= '0;
      fdiv       <= '0;
      bit_tick   <= 1'b0;
      rx_en      <= 1'b0;
      frame_tick <= 1'b0;
      fsync      <= 1'b0;
    end else begin
      bit_tick   <= 1'b0;
      rx_en      <= 1'b0;
      frame_tick <= 1'b0;
      if (cfg_wr) cfg <= cfg_wdata[CW-1:0];
      if (src_chg) begin
        bcnt  <= '0;
        fcnt  <= '0;
        bdiv  <= cfg_wdata[CW-1:FDIV_W+1];
        fdiv  <= cfg_wdata[FDIV_W:1];
        fsync <= 1'b0;
      end else if (sel) begin
        rx_en <= (bcnt == rx_idx);
        if (bcnt == bdiv) begin
          bcnt       <= '0;
          bdiv       <= cfg[CW-1:FDIV_W+1];
          bit_tick   <= 1'b1;
          frame_tick <= (fcnt == '0);
          fsync      <= (fcnt == '0);
          if (fcnt == fdiv) begin
            fcnt <= '0;
            fdiv <= cfg[FDIV_W:1];
          end else begin
            fcnt <= fcnt + 1'b1;
          end
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end
    end
  end

  assert_tick_from_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> $past(sel));
  assert_bit_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt <= bdiv);
  assert_frame_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= fdiv);
  assert_frame_on_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |-> (bit_tick && fsync));
  assert_fsync_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_tick && !$past(src_chg)) |-> $stable(fsync));
  assert_rx_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en |-> $past(sel));
  assert_restart_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    src_chg |=> (!bit_tick && !frame_tick && !fsync && !rx_en));
endmodule

// File: tb/audio_clkgen_tb.sv
module audio_clkgen_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic aux_tick = 1'b0, hs_tick = 1'b0;
  logic bit_tick, rx_en, frame_tick, fsync;

  int errors = 0, checks = 0;
  bit done = 0;
  bit cnt_en = 0;
  int n_bits, n_frames, n_fsbits, n_rx;
  logic s_bt, s_ft, s_fs, s_rx;

  always #2 clk = ~clk;

  audio_clkgen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .aux_tick(aux_tick), .hs_tick(hs_tick), .bit_tick(bit_tick),
    .rx_en(rx_en), .frame_tick(frame_tick), .fsync(fsync)
  );

  always @(negedge clk) if (cnt_en) begin
    n_bits   += int'(bit_tick);
    n_frames += int'(frame_tick);
    n_fsbits += int'(bit_tick && fsync);
    n_rx     += int'(rx_en);
  end

  // {cfg, strobes, expected bit ticks, expected frame ticks}
  localparam logic [47:0] VEC [6] = '{
    {16'h0000, 12'd8,   12'd8,   8'd8},
    {16'h0107, 12'd20,  12'd10,  8'd3},
    {16'h0202, 12'd13,  12'd4,   8'd2},
    {16'h0405, 12'd25,  12'd5,   8'd2},
    {16'h00FE, 12'd256, 12'd256, 8'd2},
    {16'hFF01, 12'd512, 12'd2,   8'd2}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic restart(input logic [15:0] d);
    wr(d ^ 16'h0001);
    wr(d);
  endtask

  // one strobe on the picked source plus extra strobes on the other one
  task automatic step(input logic src, input int j);
    @(negedge clk);
    if (src) begin hs_tick = 1'b1; aux_tick = (j % 2 == 0); end
    else     begin aux_tick = 1'b1; hs_tick = (j % 2 == 0); end
    @(negedge clk);
    s_bt = bit_tick; s_ft = frame_tick; s_fs = fsync; s_rx = rx_en;
    hs_tick = ~src; aux_tick = src;
    @(negedge clk);
    hs_tick = 1'b0; aux_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 bit_tick reset", int'(bit_tick), 0);
    check("R1 frame_tick reset", int'(frame_tick), 0);
    check("R1 fsync reset", int'(fsync), 0);
    check("R1 rx_en reset", int'(rx_en), 0);

    @(negedge clk); hs_tick = 1'b1;
    @(negedge clk); hs_tick = 1'b0;
    check("R2 unpicked hs ignored", int'(bit_tick), 0);
    step(1'b0, 1);
    check("R1 default div1 bit", int'(s_bt), 1);
    check("R1 default div1 frame", int'(s_ft), 1);

    foreach (VEC[i]) begin
      logic [15:0] c;
      int m, nb, ridx, exp_rx;
      c = VEC[i][47:32];
      m = int'(VEC[i][31:20]);
      nb = int'(c[15:8]) + 1;
      ridx = (nb == 1) ? 0 : nb / 2 - 1;
      exp_rx = 0;
      for (int j = 0; j < m; j++) if (j % nb == ridx) exp_rx++;
      restart(c);
      n_bits = 0; n_frames = 0; n_fsbits = 0; n_rx = 0;
      cnt_en = 1;
      for (int j = 0; j < m; j++) step(c[0], j);
      repeat (3) @(negedge clk);
      cnt_en = 0;
      @(negedge clk);
      check("R3 R2 bit tick count", n_bits, int'(VEC[i][19:8]));
      check("R4 R5 frame tick count", n_frames, int'(VEC[i][7:0]));
      check("R6 fsync on frame bits", n_fsbits, int'(VEC[i][7:0]));
      check("R7 rx enable count", n_rx, exp_rx);
    end

    restart(16'h0300);
    step(1'b0, 0); step(1'b0, 1);
    wr(16'h0100);
    step(1'b0, 2);
    check("R8 old period kept s3", int'(s_bt), 0);
    step(1'b0, 3);
    check("R8 old period ends s4", int'(s_bt), 1);
    step(1'b0, 4);
    check("R8 new ratio s5", int'(s_bt), 0);
    step(1'b0, 5);
    check("R8 new ratio s6", int'(s_bt), 1);

    restart(16'h0105);
    step(1'b1, 0);
    step(1'b1, 1);
    check("R6 frame start fsync", int'(s_fs), 1);
    step(1'b1, 2);
    check("R6 fsync held mid bit", int'(s_fs), 1);
    step(1'b1, 3);
    check("R6 fsync drops next bit", int'(s_fs), 0);
    check("R4 no frame on bit 1", int'(s_ft), 0);

    restart(16'h0200);
    step(1'b0, 0); step(1'b0, 1);
    wr(16'h0201);
    check("R9 fsync cleared", int'(fsync), 0);
    step(1'b1, 0);
    check("R9 fresh period s1", int'(s_bt), 0);
    step(1'b1, 1);
    check("R9 fresh period s2", int'(s_bt), 0);
    step(1'b1, 2);
    check("R9 tick after full period", int'(s_bt), 1);
    check("R9 restart begins frame", int'(s_ft), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule